// File: doc/BRIEF.md
# Delayed-Write Synchronous SRAM Core

A single-port synchronous static RAM of 2^ADDR_W words, each LANES byte lanes of LANE_W bits (four 9-bit lanes, 36 bits per word). Address, chip select, write enable and lane enables are registered on the rising clock edge. Write data follows one cycle behind its address. It is parked in a write store register and only reaches the array when the next write's data arrives. A read of the parked address therefore merges the parked lanes into the array word. With ADDR_W set to 15 the array has 32768 words. The default of 10 keeps elaboration small.

Two select pins choose how read data reaches the bus. The registered style drives it one cycle later. The flow-through style drives it in the same cycle. The latched style drives it through a transparent latch that opens while the clock is low. The bidirectional bus is split into dq_in, dq_out and dq_oe. Output enable and sleep gate dq_oe without waiting for a clock edge.

Top module: `dwsram`

## Requirements
- R1: Every word written with all lanes enabled reads back unchanged at any address.
- R2: The data for a write sampled at edge k is taken from dq_in at edge k+1.
- R3: A write changes only lane i (bits 9i+8 down to 9i) for each be_n[i] that is low. All other lanes keep their stored value.
- R4: A write with be_n all high changes no stored bit and leaves any parked write intact.
- R5: A read sampled at the edge that captures a write's data, or any later edge, returns the written lanes merged with the array lanes. This holds even while the write is still parked.
- R6: With {pipe_sel1,pipe_sel2}=01 (and also 11), data for a read sampled at edge n is driven in the cycle between edges n+1 and n+2.
- R7: With {pipe_sel1,pipe_sel2}=00, data for a read sampled at edge n is driven in the cycle that follows edge n.
- R8: With {pipe_sel1,pipe_sel2}=10, data for a read sampled at edge n is driven during the low clock phase after edge n. The latch holds that data through the next high phase.
- R9: An edge with cs_n high performs no access. After two such edges dq_oe is low.
- R10: While oe_n is high, dq_oe is low, and the change takes effect without waiting for a clock edge.
- R11: While sleep is high, dq_oe is low. An edge with sleep high performs no read or write.
- R12: dq_oe is low throughout the cycle in which a write's data is on dq_in, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Active-low reset of the pipeline state (the array keeps its contents) |
| sleep | input | 1 | Power-down: no access, bus released |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Low for a write, high for a read |
| be_n | input | LANES | Active-low lane write enables |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Active-low output enable, combinational |
| pipe_sel1 | input | 1 | Output style select, first pin |
| pipe_sel2 | input | 1 | Output style select, second pin |
| dq_in | input | LANES*LANE_W | Bus data coming in (write data) |
| dq_out | output | LANES*LANE_W | Bus data going out (read data) |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
Suppose the write store loses a parked write, or commits it to the wrong address. The error stays hidden until the word is read back, and then it shows as wrong lanes on dq_out. A read in the cycle right after the data edge exposes a broken merge at once. A wrong mode decode or a wrong pipeline depth moves dq_oe by a full cycle or a half cycle. This is caught on the first read, because every sample is compared against a model of the expected timing. A bus turnaround fault appears as dq_oe high during a write data cycle and is caught in that same cycle.

// File: rtl/dwsram.sv
`timescale 1ns/100ps
module dwsram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sleep,
  input  logic                      cs_n,
  input  logic                      we_n,
  input  logic [LANES-1:0]          be_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      oe_n,
  input  logic                      pipe_sel1,
  input  logic                      pipe_sel2,
  input  logic [LANES*LANE_W-1:0]   dq_in,
  output logic [LANES*LANE_W-1:0]   dq_out,
  output logic                      dq_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_NOP, OP_RD, OP_WR} op_t;

  op_t               op_r;
  logic [ADDR_W-1:0] addr_r;
  logic [LANES-1:0]  mask_r;

  logic              wst_valid;
  logic [ADDR_W-1:0] wst_addr;
  logic [LANES-1:0]  wst_mask;
  logic [DW-1:0]     wst_data;

  logic [DW-1:0]     mem [DEPTH];
  logic [DW-1:0]     rdata;
  logic              rr_v, lat_v, out_v;
  logic [DW-1:0]     rr_d, lat_d, out_d;

  wire data_edge = (op_r == OP_WR) && (|mask_r);
  wire mode_ft   = !pipe_sel1 && !pipe_sel2;
  wire mode_rl   =  pipe_sel1 && !pipe_sel2;
  wire hit       = wst_valid && (wst_addr == addr_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_r   <= OP_NOP;
      addr_r <= '0;
      mask_r <= '0;
    end else begin
      op_r   <= (sleep || cs_n) ? OP_NOP : (we_n ? OP_RD : OP_WR);
      addr_r <= addr;
      mask_r <= ~be_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wst_valid <= 1'b0;
      wst_addr  <= '0;
      wst_mask  <= '0;
      wst_data  <= '0;
    end else if (data_edge) begin
      wst_valid <= 1'b1;
      wst_addr  <= addr_r;
      wst_mask  <= mask_r;
      wst_data  <= dq_in;
    end
  end

  always_ff @(posedge clk) begin
    if (data_edge && wst_valid)
      for (int l = 0; l < LANES; l++)
        if (wst_mask[l]) mem[wst_addr][l*LANE_W +: LANE_W] <= wst_data[l*LANE_W +: LANE_W];
  end

  always_comb begin
    rdata = mem[addr_r];
    for (int l = 0; l < LANES; l++)
      if (hit && wst_mask[l]) rdata[l*LANE_W +: LANE_W] = wst_data[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_v <= 1'b0;
      rr_d <= '0;
    end else begin
      rr_v <= (op_r == OP_RD);
      rr_d <= rdata;
    end
  end

  always_latch begin
    if (!rst_n) begin
      lat_v <= 1'b0;
      lat_d <= '0;
    end else if (!clk) begin
      lat_v <= (op_r == OP_RD);
      lat_d <= rdata;
    end
  end

  always_comb begin
    if (mode_ft) begin
      out_v = (op_r == OP_RD);
      out_d = rdata;
    end else if (mode_rl) begin
      out_v = lat_v;
      out_d = lat_d;
    end else begin
      out_v = rr_v;
      out_d = rr_d;
    end
  end

  assign dq_out = out_d;
  assign dq_oe  = !sleep && !oe_n && out_v && (op_r != OP_WR);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  wire rd_req = !sleep && !cs_n && we_n;
  wire wr_req = !sleep && !cs_n && !we_n;
  wire idle   = sleep || cs_n;

  AST_WR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(wr_req)) |-> !dq_oe); // R12
  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(idle) && $past(idle, 2)) |-> !dq_oe); // R9
  AST_FAST_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !pipe_sel2 && dq_oe) |-> $past(rd_req)); // R7
  AST_REG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && pipe_sel2 && dq_oe) |-> $past(rd_req, 2)); // R6
  AST_ABORT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(op_r == OP_WR && mask_r == '0)) |-> ($stable(wst_data) && $stable(wst_valid))); // R4
endmodule

// File: tb/dwsram_tb.sv
`timescale 1ns/100ps
module dwsram_tb;
  logic clk = 1'b0, rst_n = 1'b0, sleep = 1'b0, cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic pipe_sel1 = 1'b0, pipe_sel2 = 1'b1;
  logic [3:0] be_n = 4'hF;
  logic [3:0] addr = 4'h0;
  logic [35:0] dq_in = '0;
  logic [35:0] dq_out;
  logic dq_oe;

  always #2 clk = ~clk;

  dwsram #(.ADDR_W(4), .LANE_W(9), .LANES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs_n(cs_n), .we_n(we_n), .be_n(be_n),
    .addr(addr), .oe_n(oe_n), .pipe_sel1(pipe_sel1), .pipe_sel2(pipe_sel2),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  int checks = 0, errors = 0, md = 0;
  logic [35:0] ref_mem [16];
  bit pw = 0, prev_rd = 0;
  logic [3:0] pa = '0, pm = '0;
  logic [35:0] pd = '0, prev_val = '0;

  function automatic logic [35:0] pat(int a, int k);
    return {4'(k + a), 32'((a + 1) * 32'h9E3779B1 + k * 32'h7F4A7C15)};
  endfunction

  task automatic chk(string tag, bit ev, logic [35:0] ed);
    checks++;
    if (dq_oe !== ev || (ev && dq_out !== ed)) begin
      errors++;
      $display("FAIL %s: dq_oe=%0b dq_out=%h expected dq_oe=%0b dq_out=%h", tag, dq_oe, dq_out, ev, ed);
    end
  endtask

  task automatic step(string tag, bit cs, bit wr, logic [3:0] msk, logic [3:0] a, logic [35:0] wd, bit slp);
    bit crd, cwr, ev;
    logic [35:0] ed;
    cs_n = !cs; we_n = !wr; be_n = ~msk; addr = a; sleep = slp;
    dq_in = pw ? pd : 36'h0;
    @(posedge clk);
    if (pw)
      for (int l = 0; l < 4; l++)
        if (pm[l]) ref_mem[pa][l*9 +: 9] = pd[l*9 +: 9];
    crd = cs && !wr && !slp;
    cwr = cs && wr && !slp;
    pw = cwr; pa = a; pm = msk; pd = wd;
    #3;
    if (md == 0) begin ev = prev_rd; ed = prev_val; end
    else begin ev = crd; ed = ref_mem[a]; end
    if (cwr || slp || oe_n) ev = 0;
    chk(tag, ev, ed);
    prev_rd = crd;
    prev_val = ref_mem[a];
  endtask

  task automatic nop(string tag);
    step(tag, 0, 0, 4'h0, 4'h0, 36'h0, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string mt;
    repeat (3) @(posedge clk);
    #3;
    chk("R9", 0, '0);
    rst_n = 1'b1;
    for (int m = 0; m < 3; m++) begin
      md = m;
      {pipe_sel1, pipe_sel2} = (m == 0) ? 2'b01 : (m == 1) ? 2'b00 : 2'b10;
      mt = (m == 0) ? "R6" : (m == 1) ? "R7" : "R8";
      nop("R9"); nop("R9");
      for (int a = 0; a < 16; a++) step("R2", 1, 1, 4'hF, 4'(a), pat(a, m), 0);
      for (int a = 0; a < 16; a++) step(mt, 1, 0, 4'h0, 4'(a), 36'h0, 0);
      nop("R1");
      for (int a = 0; a < 16; a++) begin
        step("R3", 1, 1, 4'(a), 4'(a), pat(a, m + 3), 0);
        step((a == 0) ? "R4" : "R5", 1, 0, 4'h0, 4'(a), 36'h0, 0);
        step("R5", 1, 0, 4'h0, 4'(a ^ 1), 36'h0, 0);
      end
      for (int a = 0; a < 16; a++) step("R3", 1, 0, 4'h0, 4'(a), 36'h0, 0);
      nop("R4");
      for (int i = 0; i < 48; i++) begin
        case (i % 6)
          0, 2:    step("R12", 1, 0, 4'h0, 4'((i * 7) % 16), 36'h0, 0);
          3:       nop("R9");
          default: step("R12", 1, 1, 4'((i * 5) % 16) | 4'h1, 4'((i * 7) % 16), pat(i, m + 9), 0);
        endcase
      end
      nop("R9"); nop("R9");
      oe_n = 1'b1;
      step("R10", 1, 0, 4'h0, 4'h2, 36'h0, 0);
      step("R10", 1, 0, 4'h0, 4'h3, 36'h0, 0);
      oe_n = 1'b0;
      step(mt, 1, 0, 4'h0, 4'h4, 36'h0, 0);
      step(mt, 1, 0, 4'h0, 4'h5, 36'h0, 0);
      oe_n = 1'b1; #0.1;
      chk("R10", 0, '0);
      oe_n = 1'b0; #0.1;
      chk("R10", 1, (m == 0) ? ref_mem[4] : ref_mem[5]);
      step("R11", 1, 0, 4'h0, 4'h3, 36'h0, 1);
      step("R11", 1, 1, 4'hF, 4'h6, ~pat(6, m), 1);
      nop("R11"); nop("R11");
      step("R11", 1, 0, 4'h0, 4'h6, 36'h0, 0);
      nop("R11"); nop("R11");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule